// File: doc/BRIEF.md
# Bridge Fault Monitor With Encoded Flags

This block supervises the two full bridges of a stepper-motor driver. Each bridge reports two digital facts: whether inductive recirculation was seen, and whether one of its outputs is shorted to ground. A thermal warning flag and a thermal shutdown flag are shared by both bridges. The block also watches each bridge's direction input and its two-bit current-level input. From all of these it keeps, for every bridge, one latch for open load and one for short to ground. It reports the combined state on two active-low fault outputs, using a fixed priority code.

When the direction of a bridge reverses, the bridge should recirculate. If no recirculation is seen inside a window of a configurable length, open load is latched. A reversal made while the bridge is at holding current counts as open load at once. A short to ground is latched at once. After a configurable delay it switches the bridge's drive permission off, and the permission stays off until the latch is cleared. A reversal clears a bridge's latches. So does setting both of its level bits high. Because the latches are kept per bridge, software can re-enable one bridge at a time and see which one is faulty.

Top module: `bridge_fault_monitor`

## Requirements
- R1: The fault outputs (fault_a_n_o, fault_b_n_o) follow a fixed code. Thermal warning gives (0,0) and wins over everything. Any latched short gives (1,0), even when open load is also latched. Open load alone gives (0,1). No fault gives (1,1).
- R2: A direction change starts a window of WIN_CYC cycles. If recirc_i stays low on every cycle from the change to the end of the window, open load is latched. The outputs show it WIN_CYC clock edges after the edge that sampled the change.
- R3: A recirc_i pulse on any cycle inside the window keeps open load from being latched.
- R4: A direction change sampled while the bridge's level is hold (bits 10) latches open load on that same edge.
- R5: gnd_short_i latches a short on the next edge, and the outputs update on that edge. That bridge's bridge_en_o falls SDLY_CYC edges later. It stays low even after gnd_short_i goes away, until the latch is cleared.
- R6: A direction change at a level other than hold clears both latches of that bridge. Level 11 (no current) clears both latches, cancels any window and holds bridge_en_o low.
- R7: Each bridge's latches and enable act on their own. A short on one bridge never lowers the other bridge's enable. Clearing one bridge leaves the other bridge's latched fault visible.
- R8: therm_off_i drives both bits of bridge_en_o low on the next edge.
- R9: Reset gives fault outputs (1,1) and bridge_en_o 0. The first direction value sampled after reset is taken as the starting value, not as a change. All outputs are registered.

Level encoding per bridge is {high bit, low bit}: 00 boost, 01 normal, 10 hold, 11 no current. Bridge b uses lvl_i[2b+1:2b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | NUM_BR | Direction input per bridge |
| lvl_i | input | 2*NUM_BR | Current-level code per bridge |
| recirc_i | input | NUM_BR | Recirculation seen, per bridge |
| gnd_short_i | input | NUM_BR | Short to ground detected, per bridge |
| therm_warn_i | input | 1 | Thermal pre-alarm |
| therm_off_i | input | 1 | Thermal shutdown |
| fault_a_n_o | output | 1 | Active-low fault code bit A |
| fault_b_n_o | output | 1 | Active-low fault code bit B |
| bridge_en_o | output | NUM_BR | Drive permission per bridge |

## Verification
The assertions assume that all inputs are synchronous to clk and settle between edges. They also assume that a level of 11 really means the bridge is idle, so clearing on it is always legal. The stimulus changes inputs only on falling edges. Each recirculation pulse and each short pulse lasts at least one full cycle, and a new direction change starts only after the previous window has ended. The one exception is the case that tests a restart inside the same cycle, where recirculation arrives together with the change.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    typedef enum logic [1:0] {
        LVL_BOOST = 2'b00,
        LVL_NORM  = 2'b01,
        LVL_HOLD  = 2'b10,
        LVL_OFF   = 2'b11
    } lvl_e;

    // Priority code for the two active-low fault pins: {a_n, b_n}
    function automatic logic [1:0] encode_faults(input logic warn,
                                                 input logic any_short,
                                                 input logic any_open);
        logic [1:0] code;
        if (warn)           code = 2'b00;
        else if (any_short) code = 2'b10;
        else if (any_open)  code = 2'b01;
        else                code = 2'b11;
        return code;
    endfunction

endpackage

// File: rtl/bfm_bridge.sv
module bfm_bridge
    import bfm_pkg::*;
#(
    parameter int WIN_CYC  = 16,
    parameter int SDLY_CYC = 3750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_i,
    input  logic [1:0] lvl_i,
    input  logic       recirc_i,
    input  logic       gnd_short_i,
    input  logic       therm_off_i,
    output logic       open_nx_o,
    output logic       short_nx_o,
    output logic       en_o
);

    localparam int WCW = (WIN_CYC  > 1) ? $clog2(WIN_CYC)  : 1;
    localparam int SCW = (SDLY_CYC > 1) ? $clog2(SDLY_CYC) : 1;
    localparam logic [WCW-1:0] WIN_LAST  = WCW'(WIN_CYC - 1);
    localparam logic [SCW-1:0] SDLY_LAST = SCW'(SDLY_CYC - 1);

    typedef struct packed {
        logic           dir;
        logic           primed;
        logic           win_act;
        logic [WCW-1:0] win_cnt;
        logic           seen;
        logic           open;
        logic           gshort;
        logic [SCW-1:0] sdly;
        logic           off;
        logic           en;
    } brg_st_t;

    brg_st_t st_d, st_q;
    logic    edge_w, lvl_off, lvl_hold;

    assign lvl_off  = (lvl_i == LVL_OFF);
    assign lvl_hold = (lvl_i == LVL_HOLD);
    assign edge_w   = st_q.primed && (dir_i != st_q.dir);

    always_comb begin
        st_d        = st_q;
        st_d.dir    = dir_i;
        st_d.primed = 1'b1;
        if (lvl_off) begin
            st_d.open    = 1'b0;
            st_d.gshort  = 1'b0;
            st_d.off     = 1'b0;
            st_d.win_act = 1'b0;
            st_d.seen    = 1'b0;
            st_d.sdly    = '0;
        end else if (edge_w) begin
            st_d.open    = lvl_hold;
            st_d.gshort  = 1'b0;
            st_d.off     = 1'b0;
            st_d.sdly    = '0;
            st_d.win_act = !lvl_hold;
            st_d.win_cnt = WIN_LAST;
            st_d.seen    = recirc_i;
        end else begin
            if (st_q.win_act) begin
                if (recirc_i) st_d.seen = 1'b1;
                if (st_q.win_cnt == '0) begin
                    st_d.win_act = 1'b0;
                    if (!(st_q.seen || recirc_i)) st_d.open = 1'b1;
                end else begin
                    st_d.win_cnt = st_q.win_cnt - 1'b1;
                end
            end
            if (gnd_short_i && !st_q.gshort) begin
                st_d.gshort = 1'b1;
                st_d.sdly   = '0;
            end else if (st_q.gshort && !st_q.off) begin
                if (st_q.sdly == SDLY_LAST) st_d.off  = 1'b1;
                else                        st_d.sdly = st_q.sdly + 1'b1;
            end
        end
        st_d.en = !st_d.off && !lvl_off && !therm_off_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_nx_o  = st_d.open;
    assign short_nx_o = st_d.gshort;
    assign en_o       = st_q.en;

    AST_OFF_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.off |-> st_q.gshort) else $error("off without short"); // R5

    AST_OFF_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.off |-> !en_o) else $error("enable while disabled"); // R5

    AST_LVL_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_off |=> (!st_q.open && !st_q.gshort && !en_o)) else $error("no-current did not clear"); // R6

    AST_HOLD_EDGE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w && lvl_hold) |=> st_q.open) else $error("hold reversal not flagged"); // R4

    AST_THERM_OFF_EN: assert property (@(posedge clk) disable iff (!rst_n)
        therm_off_i |=> !en_o) else $error("enable during shutdown"); // R8

endmodule

// File: rtl/bfm_encoder.sv
module bfm_encoder
    import bfm_pkg::*;
#(
    parameter int NUM_BR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BR-1:0] open_v_i,
    input  logic [NUM_BR-1:0] short_v_i,
    input  logic              warn_i,
    output logic              fault_a_n_o,
    output logic              fault_b_n_o
);

    typedef struct packed {
        logic a_n;
        logic b_n;
    } enc_st_t;

    enc_st_t st_d, st_q;

    always_comb begin
        {st_d.a_n, st_d.b_n} = encode_faults(warn_i, |short_v_i, |open_v_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{a_n: 1'b1, b_n: 1'b1};
        else        st_q <= st_d;
    end

    assign fault_a_n_o = st_q.a_n;
    assign fault_b_n_o = st_q.b_n;

    AST_WARN_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        warn_i |=> (!fault_a_n_o && !fault_b_n_o)) else $error("warn code wrong"); // R1

    AST_SHORT_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!warn_i && |short_v_i) |=> (fault_a_n_o && !fault_b_n_o)) else $error("short code wrong"); // R1

    AST_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!warn_i && !(|short_v_i) && !(|open_v_i)) |=> (fault_a_n_o && fault_b_n_o)) else $error("idle code wrong"); // R1

endmodule

// File: rtl/bridge_fault_monitor.sv
module bridge_fault_monitor
    import bfm_pkg::*;
#(
    parameter int NUM_BR   = 2,
    parameter int WIN_CYC  = 16,
    parameter int SDLY_CYC = 3750
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BR-1:0]   dir_i,
    input  logic [2*NUM_BR-1:0] lvl_i,
    input  logic [NUM_BR-1:0]   recirc_i,
    input  logic [NUM_BR-1:0]   gnd_short_i,
    input  logic                therm_warn_i,
    input  logic                therm_off_i,
    output logic                fault_a_n_o,
    output logic                fault_b_n_o,
    output logic [NUM_BR-1:0]   bridge_en_o
);

    logic [NUM_BR-1:0] open_v, short_v;

    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
        bfm_bridge #(
            .WIN_CYC  (WIN_CYC),
            .SDLY_CYC (SDLY_CYC)
        ) i_br (
            .clk         (clk),
            .rst_n       (rst_n),
            .dir_i       (dir_i[b]),
            .lvl_i       (lvl_i[2*b+1 -: 2]),
            .recirc_i    (recirc_i[b]),
            .gnd_short_i (gnd_short_i[b]),
            .therm_off_i (therm_off_i),
            .open_nx_o   (open_v[b]),
            .short_nx_o  (short_v[b]),
            .en_o        (bridge_en_o[b])
        );
    end

    bfm_encoder #(.NUM_BR(NUM_BR)) i_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_v_i    (open_v),
        .short_v_i   (short_v),
        .warn_i      (therm_warn_i),
        .fault_a_n_o (fault_a_n_o),
        .fault_b_n_o (fault_b_n_o)
    );

endmodule

// File: tb/test_bridge_fault_monitor.sv
`timescale 1ns/1ps
module test_bridge_fault_monitor;

    localparam int NB = 2;
    localparam int W  = 16;
    localparam int SD = 3750;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] dir_i = '0;
    logic [2*NB-1:0] lvl_i = 4'b0101;
    logic [NB-1:0] recirc_i = '0;
    logic [NB-1:0] gnd_short_i = '0;
    logic          therm_warn_i = 1'b0;
    logic          therm_off_i = 1'b0;
    logic          fault_a_n_o, fault_b_n_o;
    logic [NB-1:0] bridge_en_o;

    always #4 clk = ~clk;

    bridge_fault_monitor #(.NUM_BR(NB), .WIN_CYC(W), .SDLY_CYC(SD)) i_bridge_fault_monitor (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .lvl_i(lvl_i), .recirc_i(recirc_i),
        .gnd_short_i(gnd_short_i), .therm_warn_i(therm_warn_i), .therm_off_i(therm_off_i),
        .fault_a_n_o(fault_a_n_o), .fault_b_n_o(fault_b_n_o), .bridge_en_o(bridge_en_o)
    );

    typedef struct {
        string      req;
        logic [3:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;
    int       n_cmp = 0;
    int       n_bad = 0;
    bit       done  = 1'b0;
    sb_item_t it;

    // monitor: compares {a_n, b_n, en[1], en[0]}
    always @(chk_ev) begin
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_cmp++;
            if ({fault_a_n_o, fault_b_n_o, bridge_en_o} !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %b expected %b", it.req,
                         {fault_a_n_o, fault_b_n_o, bridge_en_o}, it.exp);
            end
        end
    end

    task automatic expect_out(input string req, input logic [3:0] e);
        sb_q.push_back('{req, e});
        -> chk_ev;
        #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R9: reset state; dir of bridge 0 high through reset
        dir_i = 2'b01;
        step(2);
        expect_out("R9 reset", 4'b1100);
        rst_n = 1'b1;
        step(2);
        expect_out("R9 enables after reset", 4'b1111);
        step(W + 3);
        expect_out("R9 first dir sample not a change", 4'b1111);

        // R3: recirculation inside window
        dir_i[0] = 1'b0;
        step(3);
        recirc_i[0] = 1'b1;
        step(1);
        recirc_i[0] = 1'b0;
        step(W);
        expect_out("R3 recirc prevents open", 4'b1111);

        // R2: no recirculation, exact timing
        dir_i[0] = 1'b1;
        step(W);
        expect_out("R2 still clear before window end", 4'b1111);
        step(1);
        expect_out("R2 open latched at window end", 4'b0111);

        // R6: level 11 clears and drops enable
        lvl_i[1:0] = 2'b11;
        step(1);
        expect_out("R6 no-current clears latch, en0 low", 4'b1110);
        lvl_i[1:0] = 2'b01;
        step(1);
        expect_out("R6 enable back", 4'b1111);

        // R4: reversal in hold mode
        lvl_i[1:0] = 2'b10;
        dir_i[0] = 1'b0;
        step(1);
        expect_out("R4 hold reversal flags open at once", 4'b0111);

        // R6: normal reversal clears
        lvl_i[1:0] = 2'b01;
        dir_i[0] = 1'b1;
        recirc_i[0] = 1'b1;
        step(1);
        recirc_i[0] = 1'b0;
        expect_out("R6 reversal clears open", 4'b1111);
        step(W + 2);
        expect_out("R6 stays clear after window", 4'b1111);

        // R1: open on bridge 0 plus short on bridge 1 -> short dominates
        lvl_i[1:0] = 2'b10;
        dir_i[0] = 1'b0;
        step(1);
        lvl_i[1:0] = 2'b01;
        expect_out("R1 open only code", 4'b0111);
        gnd_short_i[1] = 1'b1;
        step(1);
        expect_out("R1 short dominates open", 4'b1011);

        // R5 / R7: delayed disable of bridge 1 only
        step(SD - 1);
        expect_out("R5 enable kept before delay", 4'b1011);
        step(1);
        expect_out("R5 R7 bridge1 off, bridge0 on", 4'b1001);
        gnd_short_i[1] = 1'b0;
        step(5);
        expect_out("R5 disable holds", 4'b1001);

        // R7: clear bridge 1, bridge 0 open stays visible
        lvl_i[3:2] = 2'b11;
        step(1);
        lvl_i[3:2] = 2'b01;
        step(1);
        expect_out("R7 bridge0 fault located", 4'b0111);

        // R1: thermal warning wins
        therm_warn_i = 1'b1;
        step(1);
        expect_out("R1 warning both low", 4'b0011);

        // R8: thermal shutdown
        therm_off_i = 1'b1;
        step(1);
        expect_out("R8 shutdown drops enables", 4'b0000);
        therm_off_i = 1'b0;
        therm_warn_i = 1'b0;
        step(1);
        expect_out("R8 enables return", 4'b0111);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule